// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. A controller state machine drives a small datapath through a set of select and load strobes. The datapath holds two working registers, one result register and one done flag. Each loop step subtracts the smaller working value from the larger one. The loop stops when the two values are equal, and that value is the result.

The engine waits while its start input is low. A start request captures both operands, one per cycle. The loop then runs, and the result is written to the output register together with a one-cycle done pulse. After that the engine goes back to waiting. A zero operand is caught before the loop starts, so the loop cannot run forever.

Top module: `gcd_engine`

## Requirements
- R1: After reset `gcdOut` is 0 and `done` is 0.
- R2: While `startReq` is low in the idle state, the engine stays idle: `done` stays 0 and `gcdOut` does not change.
- R3: `opA` and `opB` are sampled only during start-up: `opA` in the first cycle after the start is accepted and `opB` in the second. Changes to them later in a computation do not affect its result.
- R4: For two nonzero operands the result is their greatest common divisor. It is reached by subtracting the smaller working value from the larger one until both are equal, and no subtraction ever underflows.
- R5: A new result appears on `gcdOut` on the same clock edge that raises `done`. `done` is high for exactly one cycle per computation.
- R6: `gcdOut` holds its value from one `done` pulse to the next.
- R7: If exactly one operand is zero, the result is the other operand. If both are zero, the result is 0. In both cases no subtraction takes place.
- R8: Suppose `startReq` is sampled high at clock edge e0 and the loop performs k subtractions. Then `done` goes high after edge e0+4+2k: two cycles of load, one compare cycle plus two cycles per subtraction, and one output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start request, sampled in the idle state |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| gcdOut | output | WIDTH | Result register |
| done | output | 1 | One-cycle pulse when gcdOut is updated |

## Verification
A wrong controller state shows up at the ports as a wrong `done` cycle. A state that skips or repeats a subtraction moves the pulse by two cycles for each step, so the latency check catches it at the end of that same computation. A select that goes to the wrong working register makes the result wrong or lets a subtraction underflow. An underflow wraps the working value, which either gives a wrong quotient or stretches the run until the per-task timeout, so it is reported within one computation. A stuck output load shows up right away, because `gcdOut` no longer changes on the `done` edge or no longer holds between pulses.

// File: rtl/gcd_pkg.sv
`timescale 1ns/1ps
package gcd_pkg;
  localparam int STATE_BITS = 4;

  typedef enum logic [STATE_BITS-1:0] {
    ST_IDLE  = 4'd0,
    ST_LOADX = 4'd1,
    ST_LOADY = 4'd2,
    ST_CMP   = 4'd3,
    ST_SUBY  = 4'd4,
    ST_SUBX  = 4'd5,
    ST_OUT   = 4'd6
  } gcd_state_e;

  typedef struct packed {
    logic xSel;
    logic xLd;
    logic ySel;
    logic yLd;
    logic dLd;
  } gcd_strobe_t;
endpackage

// File: rtl/gcd_ctrl.sv
`timescale 1ns/1ps
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        xNeqY,
  input  logic        xLtY,
  input  logic        xZero,
  input  logic        yZero,
  output gcd_strobe_t strobe
);
  gcd_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE:  if (startReq) stateNext = ST_LOADX;
      ST_LOADX: begin
        strobe.xLd = 1'b1;
        stateNext  = ST_LOADY;
      end
      ST_LOADY: begin
        strobe.yLd = 1'b1;
        stateNext  = ST_CMP;
      end
      ST_CMP: begin
        if (xZero || yZero || !xNeqY) stateNext = ST_OUT;
        else if (xLtY)                stateNext = ST_SUBY;
        else                          stateNext = ST_SUBX;
      end
      ST_SUBY: begin
        strobe.ySel = 1'b1;
        strobe.yLd  = 1'b1;
        stateNext   = ST_CMP;
      end
      ST_SUBX: begin
        strobe.xSel = 1'b1;
        strobe.xLd  = 1'b1;
        stateNext   = ST_CMP;
      end
      ST_OUT: begin
        strobe.dLd = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2: idle with no request stays idle
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startReq) |=> (state == ST_IDLE));

  // R5: at most one register is loaded per cycle
  a_r5_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.xLd, strobe.yLd, strobe.dLd}));
endmodule

// File: rtl/gcd_dpath.sv
`timescale 1ns/1ps
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  gcd_strobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             xNeqY,
  output logic             xLtY,
  output logic             xZero,
  output logic             yZero,
  output logic [WIDTH-1:0] gcdOut,
  output logic             done
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] xReg, yReg, xNext, yNext, dNext;

  assign xNext = strobe.xSel ? (xReg - yReg) : opA;
  assign yNext = strobe.ySel ? (yReg - xReg) : opB;
  assign dNext = xZero ? yReg : xReg;

  assign xNeqY = (xReg != yReg);
  assign xLtY  = (xReg < yReg);
  assign xZero = (xReg == ZERO);
  assign yZero = (yReg == ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg   <= '0;
      yReg   <= '0;
      gcdOut <= '0;
      done   <= 1'b0;
    end else begin
      if (strobe.xLd) xReg <= xNext;
      if (strobe.yLd) yReg <= yNext;
      if (strobe.dLd) gcdOut <= dNext;
      done <= strobe.dLd;
    end
  end

  // R4: a subtraction is only taken from the strictly larger value
  a_r4_no_underflow_x: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xLd && strobe.xSel) |-> (xReg > yReg));
  a_r4_no_underflow_y: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.yLd && strobe.ySel) |-> (yReg > xReg));

  // R4/R7: output is loaded only once the loop has converged or a zero was seen
  a_r4_load_when_equal: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dLd |-> (xZero || yZero || (xReg == yReg)));

  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: result is held between loads
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dLd |=> $stable(gcdOut));
endmodule

// File: rtl/gcd_engine.sv
`timescale 1ns/1ps
module gcd_engine
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] gcdOut,
  output logic             done
);
  gcd_strobe_t strobe;
  logic xNeqY, xLtY, xZero, yZero;

  gcd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .xNeqY(xNeqY), .xLtY(xLtY), .xZero(xZero), .yZero(yZero),
    .strobe(strobe)
  );

  gcd_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB),
    .xNeqY(xNeqY), .xLtY(xLtY), .xZero(xZero), .yZero(yZero),
    .gcdOut(gcdOut), .done(done)
  );
endmodule

// File: tb/gcd_engine_test.sv
`timescale 1ns/1ps
module gcd_engine_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] gcdOut;
  logic         done;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  gcd_engine #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .opA(opA), .opB(opB), .gcdOut(gcdOut), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: result and subtraction count
  task automatic refGcd(input int a, input int b, output int res, output int subs);
    int x = a;
    int y = b;
    subs = 0;
    if (x == 0 || y == 0) begin
      res = x | y;
      return;
    end
    while (x != y) begin
      if (x < y) y = y - x;
      else       x = x - y;
      subs++;
    end
    res = x;
  endtask

  // start a run, optionally corrupt operands mid-run, check result and latency
  task automatic runCase(input int a, input int b, input bit disturb, input string tag);
    int expRes, subs, cnt, hi;
    bit seen;
    refGcd(a, b, expRes, subs);
    @(negedge clk);
    opA = a[W-1:0];
    opB = b[W-1:0];
    startReq = 1'b1;
    cnt = 0;
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) startReq = 1'b0;
      if (disturb && cnt == 3) begin
        opA = 16'd5;
        opB = 16'd3;
      end
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    check(seen, {tag, " R5 done seen"}, seen, 1);
    check(gcdOut == expRes[W-1:0], {tag, " R4 result"}, gcdOut, expRes);
    check(cnt == 5 + 2*subs, {tag, " R8 latency"}, cnt, 5 + 2*subs);
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) hi++;
      if (gcdOut != expRes[W-1:0]) hi += 100;
    end
    check(hi == 0, {tag, " R5 R6 single pulse and hold"}, hi, 0);
  endtask

  task automatic testReset();
    check(gcdOut == 0, "R1 gcdOut after reset", gcdOut, 0);
    check(done == 0, "R1 done after reset", done, 0);
  endtask

  task automatic testIdle();
    int bad = 0;
    logic [W-1:0] held;
    held = gcdOut;
    opA = 16'd30;
    opB = 16'd12;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done || gcdOut != held) bad++;
    end
    check(bad == 0, "R2 idle without start", bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    runCase(42, 8, 1'b0, "R4 42,8");
    testIdle();
    runCase(7, 7, 1'b0, "R4 equal");
    runCase(17, 5, 1'b0, "R4 coprime");
    runCase(8, 42, 1'b0, "R4 swapped");
    runCase(48, 18, 1'b1, "R3 operands changed mid-run");
    runCase(0, 9, 1'b0, "R7 zero first");
    runCase(12, 0, 1'b0, "R7 zero second");
    runCase(0, 0, 1'b0, "R7 both zero");
    runCase(65535, 65535, 1'b0, "R4 max equal");
    runCase(65535, 21845, 1'b0, "R4 large multiple");
    runCase(1000, 1, 1'b0, "R4 long loop");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule